// File: doc/BRIEF.md
# Push-Down Stack Pointer Unit

This unit updates a 36-bit stack pointer word held in an accumulator. It performs five operations: push a datum, pop a datum, push a return address, pop a return address, and adjust the pointer by a signed offset. The pointer has two formats. In the short format the upper half is a count and the lower half is an address, and each step moves both halves together. In the long format the whole word is a flat address. Overflow and underflow are not checked against a limit register. They are taken from the carry out of the pointer arithmetic, or, for a short-pointer adjust, from a sign change in the count half.

The unit does not move data to or from memory and does not redirect instruction fetch. Instead it raises a write strobe with address and data, or a read strobe with an address, and then waits for the read word. When the operation finishes it presents the new pointer with a write-back strobe. A pop presents the popped word, and a return pop presents a jump address. A one-cycle trap pulse is raised when the pointer overflows or underflows. The trap never blocks the store, the load or the pointer write-back.

Top module: `spu_stack_unit`

## Requirements
- R1: While reset is held, busy_o, sp_we_o, mem_wr_o, mem_rd_o, pop_valid_o, jump_o and trap_o are all low.
- R2: The short format applies when the upper half of sp_i is nonzero and sec0_i is high; otherwise the long format applies. The step is 1 added to each half (short) or 1 added to the whole word (long). The memory address is the zero-extended lower half of the pointer (short) or its low ADDR_W bits (long).
- R3: A push (op_i = 0) accepted at a clock edge produces, one cycle later and for one cycle: sp_we_o and mem_wr_o high, sp_o = sp_i + step (mod 2^W), mem_addr_o taken from that new pointer, and mem_wdata_o = data_i.
- R4: A push also raises trap_o in that same cycle exactly when sp_i + step carries out of the top bit. The store and the write-back still take place.
- R5: A pop (op_i = 1) raises mem_rd_o for one cycle, one cycle after acceptance, with the address taken from the old pointer, and busy_o stays high until the read returns. One cycle after the edge at which rd_valid_i is high, the unit raises pop_valid_o with pop_data_o = rd_data_i, sp_we_o with sp_o = sp_i - step (mod 2^W), and trap_o exactly when sp_i < step (unsigned).
- R6: A return push (op_i = 2) behaves like R3 and R4, except for the stored word. With sec0_i high the word is {flags_i, low half of pc_i+1}. Otherwise it is pc_i+1 (mod 2^ADDR_W), zero-extended.
- R7: A return pop (op_i = 3) behaves like R5, except that it raises jump_o instead of pop_valid_o. The jump address is the lower half of the read word, zero-extended, when sec0_i was high at acceptance, and its low ADDR_W bits otherwise.
- R8: An adjust (op_i = 4) on a short pointer adds the sign-extended offset_i to each half separately, with no carry between halves. One cycle later sp_we_o is high and no memory strobe is raised.
- R9: In a short adjust, trap_o is raised in two cases: a non-negative offset turns a negative count non-negative, or a negative offset turns a non-negative count negative.
- R10: An adjust on a long pointer adds offset_i, sign-extended to W bits, to the whole word and never raises trap_o.
- R11: An operation presented while busy_o is high, or with op_i set to 5, 6 or 7, has no effect. The next cycle shows no strobe and no write-back.
- R12: Whenever trap_o is high, sp_we_o is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation request, taken when the unit is idle |
| op_i | input | 3 | 0 push, 1 pop, 2 return push, 3 return pop, 4 adjust |
| sec0_i | input | 1 | Current section is zero |
| sp_i | input | 2*HALF_W | Current pointer word |
| data_i | input | 2*HALF_W | Datum to push |
| pc_i | input | ADDR_W | Program counter of the calling instruction |
| flags_i | input | HALF_W | Processor flags saved by a return push in section zero |
| offset_i | input | HALF_W | Signed adjust offset |
| rd_valid_i | input | 1 | Read word available |
| rd_data_i | input | 2*HALF_W | Read word |
| busy_o | output | 1 | Waiting for a read |
| sp_we_o | output | 1 | Pointer write-back strobe |
| sp_o | output | 2*HALF_W | Updated pointer |
| mem_wr_o | output | 1 | Store strobe |
| mem_rd_o | output | 1 | Load strobe |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 2*HALF_W | Store word |
| pop_valid_o | output | 1 | Popped word valid |
| pop_data_o | output | 2*HALF_W | Popped word |
| jump_o | output | 1 | Return jump strobe |
| jump_addr_o | output | ADDR_W | Return jump address |
| trap_o | output | 1 | Overflow or underflow trap pulse |

## Verification
Push, return push and adjust results are due in the cycle right after the accepting edge. For a pop, the load strobe is due one cycle after acceptance and the pointer, data and trap are due one cycle after the edge that sees rd_valid_i. The bench drives every input on a falling edge. It reads results at the first falling edge after the edge that registers them, so each strobe is checked inside its single high cycle. The return-data handshake is driven in the same cycle that the load strobe is seen, which covers the shortest read latency.

// File: rtl/spu_pkg.sv
package spu_pkg;
  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_PUSHR = 3'd2,
    OP_POPR  = 3'd3,
    OP_ADJ   = 3'd4
  } spu_op_e;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } spu_state_e;
endpackage

// File: rtl/spu_step.sv
module spu_step #(
  parameter int HALF_W = 18,
  parameter int ADDR_W = 23
) (
  input  logic [2*HALF_W-1:0] sp_i,
  input  logic                short_i,
  input  logic                dec_i,
  output logic [2*HALF_W-1:0] next_o,
  output logic                trap_o,
  output logic [ADDR_W-1:0]   old_addr_o,
  output logic [ADDR_W-1:0]   new_addr_o
);
  localparam int W = 2 * HALF_W;
  localparam logic [W-1:0] HMASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  localparam logic [W-1:0] STEP_S = {{(HALF_W-1){1'b0}}, 1'b1, {(HALF_W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] STEP_L = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] step;
  logic [W:0]   sum;

  always_comb begin
    step = short_i ? STEP_S : STEP_L;
    // bit W is carry on add and borrow on subtract
    sum  = dec_i ? ({1'b0, sp_i} - {1'b0, step}) : ({1'b0, sp_i} + {1'b0, step});
  end

  assign next_o = sum[W-1:0];
  assign trap_o = sum[W];

  assign old_addr_o = short_i ? (sp_i[ADDR_W-1:0] & HMASK[ADDR_W-1:0]) : sp_i[ADDR_W-1:0];
  assign new_addr_o = short_i ? (sum[ADDR_W-1:0] & HMASK[ADDR_W-1:0]) : sum[ADDR_W-1:0];
endmodule

// File: rtl/spu_adjust.sv
module spu_adjust #(
  parameter int HALF_W = 18
) (
  input  logic [2*HALF_W-1:0] sp_i,
  input  logic [HALF_W-1:0]   off_i,
  input  logic                short_i,
  output logic [2*HALF_W-1:0] sp_o,
  output logic                trap_o
);
  localparam int W = 2 * HALF_W;

  logic [HALF_W-1:0] cnt, adr, cnt_n, adr_n;
  logic [W-1:0]      long_n;
  logic              off_neg;

  always_comb begin
    cnt     = sp_i[W-1:HALF_W];
    adr     = sp_i[HALF_W-1:0];
    off_neg = off_i[HALF_W-1];
    cnt_n   = cnt + off_i;
    adr_n   = adr + off_i;
    long_n  = sp_i + {{HALF_W{off_neg}}, off_i};
    sp_o    = short_i ? {cnt_n, adr_n} : long_n;
    if (!short_i)    trap_o = 1'b0;
    else if (off_neg) trap_o = !cnt[HALF_W-1] && cnt_n[HALF_W-1];
    else              trap_o = cnt[HALF_W-1] && !cnt_n[HALF_W-1];
  end
endmodule

// File: rtl/spu_ret_fmt.sv
module spu_ret_fmt #(
  parameter int HALF_W = 18,
  parameter int ADDR_W = 23
) (
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [HALF_W-1:0]   flags_i,
  input  logic                ret_sec0_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  input  logic                jmp_sec0_i,
  output logic [2*HALF_W-1:0] ret_word_o,
  output logic [ADDR_W-1:0]   jump_addr_o
);
  localparam int W = 2 * HALF_W;
  localparam logic [W-1:0] HMASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic [ADDR_W-1:0] pc1;
  assign pc1 = pc_i + 1'b1;

  assign ret_word_o  = ret_sec0_i ? {flags_i, pc1[HALF_W-1:0]} : W'(pc1);
  assign jump_addr_o = jmp_sec0_i ? (rd_addr_i & HMASK[ADDR_W-1:0]) : rd_addr_i;
endmodule

// File: rtl/spu_stack_unit.sv
module spu_stack_unit
  import spu_pkg::*;
#(
  parameter int HALF_W = 18,
  parameter int ADDR_W = 23
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [2:0]          op_i,
  input  logic                sec0_i,
  input  logic [2*HALF_W-1:0] sp_i,
  input  logic [2*HALF_W-1:0] data_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [HALF_W-1:0]   flags_i,
  input  logic [HALF_W-1:0]   offset_i,
  input  logic                rd_valid_i,
  input  logic [2*HALF_W-1:0] rd_data_i,
  output logic                busy_o,
  output logic                sp_we_o,
  output logic [2*HALF_W-1:0] sp_o,
  output logic                mem_wr_o,
  output logic                mem_rd_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*HALF_W-1:0] mem_wdata_o,
  output logic                pop_valid_o,
  output logic [2*HALF_W-1:0] pop_data_o,
  output logic                jump_o,
  output logic [ADDR_W-1:0]   jump_addr_o,
  output logic                trap_o
);
  localparam int W = 2 * HALF_W;

  spu_state_e        state_q;
  logic              acc, short_fmt, is_pop;
  logic [W-1:0]      step_next, adj_sp, ret_word, pend_sp_q;
  logic              step_trap, adj_trap, pend_trap_q, pop_ret_q, sec0_q;
  logic [ADDR_W-1:0] old_addr, new_addr, fmt_jump;

  assign acc       = op_valid_i && (state_q == ST_IDLE);
  assign short_fmt = (sp_i[W-1:HALF_W] != '0) && sec0_i;
  assign is_pop    = (op_i == OP_POP) || (op_i == OP_POPR);
  assign busy_o    = (state_q != ST_IDLE);

  spu_step #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_step (
    .sp_i      (sp_i),
    .short_i   (short_fmt),
    .dec_i     (is_pop),
    .next_o    (step_next),
    .trap_o    (step_trap),
    .old_addr_o(old_addr),
    .new_addr_o(new_addr)
  );

  spu_adjust #(.HALF_W(HALF_W)) u_adj (
    .sp_i   (sp_i),
    .off_i  (offset_i),
    .short_i(short_fmt),
    .sp_o   (adj_sp),
    .trap_o (adj_trap)
  );

  spu_ret_fmt #(.HALF_W(HALF_W), .ADDR_W(ADDR_W)) u_fmt (
    .pc_i       (pc_i),
    .flags_i    (flags_i),
    .ret_sec0_i (sec0_i),
    .rd_addr_i  (rd_data_i[ADDR_W-1:0]),
    .jmp_sec0_i (sec0_q),
    .ret_word_o (ret_word),
    .jump_addr_o(fmt_jump)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sp_we_o     <= 1'b0;
      sp_o        <= '0;
      mem_wr_o    <= 1'b0;
      mem_rd_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      pop_valid_o <= 1'b0;
      pop_data_o  <= '0;
      jump_o      <= 1'b0;
      jump_addr_o <= '0;
      trap_o      <= 1'b0;
      pend_sp_q   <= '0;
      pend_trap_q <= 1'b0;
      pop_ret_q   <= 1'b0;
      sec0_q      <= 1'b0;
    end else begin
      sp_we_o     <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_rd_o    <= 1'b0;
      pop_valid_o <= 1'b0;
      jump_o      <= 1'b0;
      trap_o      <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (op_valid_i) begin
            case (op_i)
              OP_PUSH, OP_PUSHR: begin
                sp_we_o     <= 1'b1;
                sp_o        <= step_next;
                trap_o      <= step_trap;
                mem_wr_o    <= 1'b1;
                mem_addr_o  <= new_addr;
                mem_wdata_o <= (op_i == OP_PUSH) ? data_i : ret_word;
              end
              OP_POP, OP_POPR: begin
                mem_rd_o    <= 1'b1;
                mem_addr_o  <= old_addr;
                pend_sp_q   <= step_next;
                pend_trap_q <= step_trap;
                pop_ret_q   <= (op_i == OP_POPR);
                sec0_q      <= sec0_i;
                state_q     <= ST_WAIT;
              end
              OP_ADJ: begin
                sp_we_o <= 1'b1;
                sp_o    <= adj_sp;
                trap_o  <= adj_trap;
              end
              default: ;
            endcase
          end
        end
        ST_WAIT: begin
          if (rd_valid_i) begin
            sp_we_o <= 1'b1;
            sp_o    <= pend_sp_q;
            trap_o  <= pend_trap_q;
            if (pop_ret_q) begin
              jump_o      <= 1'b1;
              jump_addr_o <= fmt_jump;
            end else begin
              pop_valid_o <= 1'b1;
              pop_data_o  <= rd_data_i;
            end
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_push_writes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (op_i == OP_PUSH || op_i == OP_PUSHR) |=> mem_wr_o && sp_we_o);

  a_r5_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  a_r5_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_wr_o, mem_rd_o, pop_valid_o, jump_o}));

  a_r10_long_adj_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && (op_i == OP_ADJ) && !short_fmt |=> !trap_o);

  a_r11_busy_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && op_valid_i |=> !mem_wr_o && !mem_rd_o);

  a_r12_trap_with_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> sp_we_o);
endmodule

// File: tb/spu_stack_unit_tb.sv
module spu_stack_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H  = 4;
  localparam int A  = 6;
  localparam int W  = 2 * H;
  localparam int HM = (1 << H) - 1;
  localparam int AM = (1 << A) - 1;
  localparam int WM = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         op_valid_i = 1'b0;
  logic [2:0]   op_i = '0;
  logic         sec0_i = 1'b0;
  logic [W-1:0] sp_i = '0, data_i = '0, rd_data_i = '0;
  logic [A-1:0] pc_i = '0;
  logic [H-1:0] flags_i = '0, offset_i = '0;
  logic         rd_valid_i = 1'b0;
  logic         busy_o, sp_we_o, mem_wr_o, mem_rd_o, pop_valid_o, jump_o, trap_o;
  logic [W-1:0] sp_o, mem_wdata_o, pop_data_o;
  logic [A-1:0] mem_addr_o, jump_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spu_stack_unit #(.HALF_W(H), .ADDR_W(A)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_i(op_i),
    .sec0_i(sec0_i), .sp_i(sp_i), .data_i(data_i), .pc_i(pc_i),
    .flags_i(flags_i), .offset_i(offset_i), .rd_valid_i(rd_valid_i),
    .rd_data_i(rd_data_i), .busy_o(busy_o), .sp_we_o(sp_we_o), .sp_o(sp_o),
    .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o),
    .jump_o(jump_o), .jump_addr_o(jump_addr_o), .trap_o(trap_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_short(int sp, bit s0);
    return ((sp >> H) != 0) && s0;
  endfunction

  function automatic int step_of(int sp, bit s0);
    return is_short(sp, s0) ? (1 << H) + 1 : 1;
  endfunction

  function automatic int addr_of(int p, bit sh);
    return sh ? (p & HM) : (p & AM);
  endfunction

  // one op, sampled one cycle after the accepting edge
  task automatic issue(input int op);
    op_i = 3'(op);
    op_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic run_push(input bit ret, input int sp, input bit s0, input int pc);
    int st, sum, nsp, word;
    bit sh;
    sp_i = W'(sp); sec0_i = s0; data_i = W'(sp ^ 8'h5A);
    pc_i = A'(pc); flags_i = H'(pc ^ 9);
    sh = is_short(sp, s0);
    st = step_of(sp, s0);
    sum = sp + st;
    nsp = sum & WM;
    if (!ret) word = (sp ^ 8'h5A) & WM;
    else if (s0) word = ((((pc ^ 9) & HM)) << H) | (((pc + 1) & AM) & HM);
    else word = (pc + 1) & AM;
    issue(ret ? 2 : 0);
    chk(mem_wr_o && sp_we_o && !mem_rd_o && sp_o == W'(nsp), "R3 push pointer", int'(sp_o), nsp);
    chk(mem_addr_o == A'(addr_of(nsp, sh)), "R2 push address", int'(mem_addr_o), addr_of(nsp, sh));
    chk(trap_o == (sum > WM), "R4 push trap", int'(trap_o), int'(sum > WM));
    if (ret) chk(mem_wdata_o == W'(word), "R6 return word", int'(mem_wdata_o), word);
    else     chk(mem_wdata_o == W'(word), "R3 push data", int'(mem_wdata_o), word);
  endtask

  task automatic run_pop(input bit ret, input int sp, input bit s0);
    int st, nsp, rd, ja;
    bit sh;
    sp_i = W'(sp); sec0_i = s0;
    sh = is_short(sp, s0);
    st = step_of(sp, s0);
    nsp = (sp - st) & WM;
    rd = (~sp ^ 8'h33) & WM;
    ja = s0 ? (rd & HM) : (rd & AM);
    issue(ret ? 3 : 1);
    chk(mem_rd_o && busy_o && !sp_we_o && mem_addr_o == A'(addr_of(sp, sh)),
        "R5 pop read", int'(mem_addr_o), addr_of(sp, sh));
    rd_valid_i = 1'b1;
    rd_data_i = W'(rd);
    @(posedge clk);
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(sp_we_o && !mem_rd_o && !busy_o && sp_o == W'(nsp), "R5 pop pointer", int'(sp_o), nsp);
    chk(trap_o == (sp < st), "R5 pop trap", int'(trap_o), int'(sp < st));
    if (ret) chk(jump_o && !pop_valid_o && jump_addr_o == A'(ja), "R7 return jump", int'(jump_addr_o), ja);
    else     chk(pop_valid_o && !jump_o && pop_data_o == W'(rd), "R5 pop data", int'(pop_data_o), rd);
  endtask

  task automatic run_adj(input int sp, input int off, input bit s0);
    int l, r, nsp, soff;
    bit trp, oneg, on, nn, sh;
    sp_i = W'(sp); sec0_i = s0; offset_i = H'(off);
    sh = is_short(sp, s0);
    oneg = (off >> (H-1)) & 1;
    if (sh) begin
      l = ((sp >> H) + off) & HM;
      r = ((sp & HM) + off) & HM;
      nsp = (l << H) | r;
      on = (sp >> (W-1)) & 1;
      nn = (l >> (H-1)) & 1;
      trp = oneg ? (!on && nn) : (on && !nn);
    end else begin
      soff = oneg ? off - (1 << H) : off;
      nsp = (sp + soff) & WM;
      trp = 1'b0;
    end
    issue(4);
    if (sh) begin
      chk(sp_we_o && !mem_wr_o && !mem_rd_o && sp_o == W'(nsp), "R8 short adjust", int'(sp_o), nsp);
      chk(trap_o == trp, "R9 short adjust trap", int'(trap_o), int'(trp));
    end else begin
      chk(sp_we_o && !mem_wr_o && !mem_rd_o && sp_o == W'(nsp), "R10 long adjust", int'(sp_o), nsp);
      chk(!trap_o, "R10 long adjust trap", int'(trap_o), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !sp_we_o && !mem_wr_o && !mem_rd_o && !pop_valid_o && !jump_o && !trap_o,
        "R1 reset state", int'({busy_o, sp_we_o, mem_wr_o, mem_rd_o, pop_valid_o, jump_o, trap_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int s = 0; s < 2; s++)
      for (int p = 0; p <= WM; p++) run_push(1'b0, p, s[0], 0);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p <= AM; p++) run_push(1'b1, (p * 37) & WM, s[0], p);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p <= WM; p++) run_pop(1'b0, p, s[0]);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p <= WM; p++) run_pop(1'b1, p, s[0]);
    for (int s = 0; s < 2; s++)
      for (int p = 0; p <= WM; p++)
        for (int o = 0; o <= HM; o++) run_adj(p, o, s[0]);

    // R11: unused op codes have no effect
    for (int c = 5; c < 8; c++) begin
      sp_i = 8'h12; sec0_i = 1'b1;
      issue(c);
      chk(!sp_we_o && !mem_wr_o && !mem_rd_o && !trap_o && !busy_o, "R11 unused code",
          int'({sp_we_o, mem_wr_o, mem_rd_o, trap_o, busy_o}), 0);
    end

    // R11: push requested while waiting on a read is dropped
    sp_i = 8'h25; sec0_i = 1'b0;
    issue(1);
    op_i = 3'd0;
    op_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    op_valid_i = 1'b0;
    chk(!mem_wr_o && !sp_we_o && !mem_rd_o && busy_o, "R11 busy ignores op",
        int'({mem_wr_o, sp_we_o, mem_rd_o, busy_o}), 1);
    rd_valid_i = 1'b1;
    rd_data_i = 8'h77;
    @(posedge clk);
    @(negedge clk);
    rd_valid_i = 1'b0;
    chk(pop_valid_o && sp_o == 8'h24, "R11 pop completes after drop", int'(sp_o), 8'h24);
    @(negedge clk);
    chk(!mem_wr_o && !sp_we_o, "R11 no late push", int'({mem_wr_o, sp_we_o}), 0);

    // R12: trap comes with write-back and lasts one cycle
    run_push(1'b0, WM, 1'b0, 0);
    chk(trap_o && sp_we_o, "R12 trap with write-back", int'({trap_o, sp_we_o}), 3);
    @(negedge clk);
    chk(!trap_o, "R12 trap single cycle", int'(trap_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule